// File: doc/BRIEF.md
# Local-Gradient Importance Scorer

This block estimates how strongly each weight of one network layer affects the loss, without a backward pass through the whole network. For a layer with `n_in` inputs and `n_out` outputs, it takes the output error vector `e` and the input feature vector `x`. It forms, for every weight `w[j][i]`, the local gradient `g = x[i] * e[j]` and the importance score `|g|`. Many lanes work side by side, so each clock produces one output beat that covers a group of adjacent weights in the same row.

Software sets the layer size and starts a job through a small AXI4-Lite register block. The error elements then arrive on one AXI4-Stream input and are held on chip. The feature elements follow on a second, wider AXI4-Stream input and are buffered. The block then sweeps the weight matrix in row-major order, with `j` as the outer loop and `i` as the inner loop. It emits (index, gradient, score) tuples on an output AXI4-Stream that honours backpressure. A status register and a tuple counter let software see when the job has ended.

Top module: `igs_scorer`

## Requirements
- R1: After reset, `out_tvalid`, `err_tready` and `feat_tready` are 0, and the status (offset 0x8) and count (offset 0xC) registers read 0.
- R2: Each kept lane carries a 32-bit two's-complement gradient equal to `x[i]*e[j]`, where the inputs are 16-bit signed. Its score equals the absolute value of that gradient. A score whose true value cannot be represented saturates to the largest positive value.
- R3: Beats leave in row-major order. `out_index` is `j*n_in + i` of lane 0, and lane k holds weight `i+k`. `out_tlast` is 1 only on the final beat of a job.
- R4: After a start, exactly `n_out` error beats are taken first, one element per beat, with `feat_tready` held at 0. Then `ceil(n_in/LANES)` feature beats are taken, with `err_tready` held at 0. Lane k of feature beat b sits at bits `[16k+15:16k]` and is element `b*LANES+k`.
- R5: In the final beat of a row, lanes whose element index is `n_in` or more have `out_tkeep` bit 0 and gradient and score 0, whatever feature data they received.
- R6: While `out_tvalid` is 1 and `out_tready` is 0, every output holds steady. No tuple is lost or repeated.
- R7: While `out_tready` is held at 1, output beats of a job leave on consecutive clocks with no gap.
- R8: Status register (0x8): bit 0 (busy) is set from an accepted start until the last beat is taken. Bit 1 (done) then sets and stays set until the next accepted start.
- R9: The count register (0xC) holds the number of kept tuples emitted since the last accepted start. After a job it equals `n_in*n_out`.
- R10: A start is ignored while busy, or when the dimensions are invalid (`n_in` is 0 or above MAX_IN, or `n_out` is 0 or above MAX_OUT). A write to the dimension register is ignored while busy.
- R11: The dimension register (0x4) holds `n_in` in bits [15:0] and `n_out` in bits [31:16] and reads back as written. Writing 1 to bit 0 of 0x0 requests a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_awvalid | input | 1 | Register write address valid |
| csr_awready | output | 1 | Register write address ready |
| csr_awaddr | input | 4 | Register write byte address |
| csr_wvalid | input | 1 | Register write data valid |
| csr_wready | output | 1 | Register write data ready |
| csr_wdata | input | 32 | Register write data |
| csr_bvalid | output | 1 | Write response valid |
| csr_bready | input | 1 | Write response ready |
| csr_bresp | output | 2 | Write response, always OKAY |
| csr_arvalid | input | 1 | Register read address valid |
| csr_arready | output | 1 | Register read address ready |
| csr_araddr | input | 4 | Register read byte address |
| csr_rvalid | output | 1 | Read data valid |
| csr_rready | input | 1 | Read data ready |
| csr_rdata | output | 32 | Read data |
| csr_rresp | output | 2 | Read response, always OKAY |
| err_tvalid | input | 1 | Error element valid |
| err_tready | output | 1 | Error element ready |
| err_tdata | input | DW | One signed error element |
| feat_tvalid | input | 1 | Feature beat valid |
| feat_tready | output | 1 | Feature beat ready |
| feat_tdata | input | LANES*DW | LANES signed feature elements |
| out_tvalid | output | 1 | Result beat valid |
| out_tready | input | 1 | Result beat ready |
| out_tlast | output | 1 | Final beat of the job |
| out_tkeep | output | LANES | Lane holds a real weight |
| out_index | output | IDXW | Weight index of lane 0 |
| out_grad | output | LANES*2*DW | Signed local gradients |
| out_score | output | LANES*2*DW | Importance scores |

## Verification
A wrong row or column counter shows up on the very next output beat as a wrong `out_index` or a wrong gradient, because each beat carries its own index and products. A bad keep computation shows up in the final beat of the first row as nonzero data in lanes past `n_in`. A stall fault shows up within one clock of a held `out_tready` as a changed or dropped beat, and later as a tuple count that no longer matches `n_in*n_out`. Faults in the status or count logic can only be seen through register reads, so those registers are read at the start of each job, while it is busy, and after it ends.

// File: rtl/igs_pkg.sv
// Package: shared state encoding and register offsets of the importance scorer.
// Assumes a 4-bit byte address on the control port, with registers on 32-bit words.
package igs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERR,
        ST_FEAT,
        ST_RUN,
        ST_DRAIN
    } seq_state_t;

    localparam logic [3:0] ADDR_CTRL  = 4'h0;
    localparam logic [3:0] ADDR_DIMS  = 4'h4;
    localparam logic [3:0] ADDR_STAT  = 4'h8;
    localparam logic [3:0] ADDR_COUNT = 4'hC;

endpackage

// File: rtl/igs_csr.sv
// Module: AXI4-Lite register block for the importance scorer.
// Holds the layer dimensions and raises a one-cycle start when the request is
// accepted. Assumes the address and data of a write arrive together; a write
// completes in the cycle both are valid and no response is outstanding.
module igs_csr
    import igs_pkg::*;
#(
    parameter int MAX_IN  = 256,
    parameter int MAX_OUT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        awvalid,
    output logic        awready,
    input  logic [3:0]  awaddr,
    input  logic        wvalid,
    output logic        wready,
    input  logic [31:0] wdata,
    output logic        bvalid,
    input  logic        bready,
    output logic [1:0]  bresp,
    input  logic        arvalid,
    output logic        arready,
    input  logic [3:0]  araddr,
    output logic        rvalid,
    input  logic        rready,
    output logic [31:0] rdata,
    output logic [1:0]  rresp,
    input  logic        busy_i,
    input  logic        done_i,
    input  logic [31:0] count_i,
    output logic [15:0] n_in_o,
    output logic [15:0] n_out_o,
    output logic        start_o
);

    localparam logic [15:0] MAX_IN_W  = 16'(MAX_IN);
    localparam logic [15:0] MAX_OUT_W = 16'(MAX_OUT);

    logic        wr_fire;
    logic        rd_fire;
    logic        dims_ok;
    logic [15:0] n_in_q;
    logic [15:0] n_out_q;

    // Purpose: accept a write when address and data are both present and no response is pending.
    assign wr_fire = awvalid && wvalid && !bvalid;
    assign awready = wr_fire;
    assign wready  = wr_fire;
    assign rd_fire = arvalid && !rvalid;
    assign arready = !rvalid;
    assign bresp   = 2'b00;
    assign rresp   = 2'b00;

    // Purpose: judge whether the stored dimensions describe a layer the buffers can hold.
    assign dims_ok = (n_in_q != 16'd0) && (n_in_q <= MAX_IN_W) &&
                     (n_out_q != 16'd0) && (n_out_q <= MAX_OUT_W);

    // Purpose: pass on a start request only when idle and the dimensions are valid.
    assign start_o = wr_fire && (awaddr == ADDR_CTRL) && wdata[0] && !busy_i && dims_ok;

    assign n_in_o  = n_in_q;
    assign n_out_o = n_out_q;

    // Purpose: hold the dimension register; writes are dropped while a job runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_in_q  <= '0;
            n_out_q <= '0;
        end else if (wr_fire && (awaddr == ADDR_DIMS) && !busy_i) begin
            n_in_q  <= wdata[15:0];
            n_out_q <= wdata[31:16];
        end
    end

    // Purpose: raise the write response after a write and drop it once it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bvalid <= 1'b0;
        end else if (wr_fire) begin
            bvalid <= 1'b1;
        end else if (bready) begin
            bvalid <= 1'b0;
        end
    end

    // Purpose: register the read data for the addressed word and hold it until taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (rd_fire) begin
            rvalid <= 1'b1;
            case (araddr)
                ADDR_DIMS:  rdata <= {n_out_q, n_in_q};
                ADDR_STAT:  rdata <= {30'd0, done_i, busy_i};
                ADDR_COUNT: rdata <= count_i;
                default:    rdata <= '0;
            endcase
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

    // R11: read data must not change while the master stalls it.
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

    // R11: a write response must stay up until it is accepted.
    p_bvalid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

endmodule

// File: rtl/igs_lane.sv
// Module: one gradient lane. Stage A forms the signed product x*e. Stage B
// registers that product as the gradient and its magnitude as the score.
// Assumes the caller gates unused lanes by zeroing x. Both stages advance only on en.
module igs_lane #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [DW-1:0]   x_i,
    input  logic [DW-1:0]   e_i,
    output logic [2*DW-1:0] grad_o,
    output logic [2*DW-1:0] score_o
);

    localparam int PW = 2 * DW;
    localparam logic [PW-1:0] MOST_NEG = {1'b1, {(PW-1){1'b0}}};
    localparam logic [PW-1:0] MOST_POS = {1'b0, {(PW-1){1'b1}}};

    logic [PW-1:0] x_ext;
    logic [PW-1:0] e_ext;
    logic [PW-1:0] p_q;
    logic [PW-1:0] mag;
    logic [PW-1:0] g_q;
    logic [PW-1:0] s_q;

    // Purpose: sign-extend both operands so the low PW bits of the product are the signed result.
    assign x_ext = {{DW{x_i[DW-1]}}, x_i};
    assign e_ext = {{DW{e_i[DW-1]}}, e_i};

    // Purpose: absolute value of the product, saturating the one value that has no positive twin.
    always_comb begin
        if (!p_q[PW-1]) begin
            mag = p_q;
        end else if (p_q == MOST_NEG) begin
            mag = MOST_POS;
        end else begin
            mag = ~p_q + 1'b1;
        end
    end

    // Purpose: two-stage lane pipeline, frozen as a whole when en is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
            g_q <= '0;
            s_q <= '0;
        end else if (en) begin
            p_q <= x_ext * e_ext;
            g_q <= p_q;
            s_q <= mag;
        end
    end

    assign grad_o  = g_q;
    assign score_o = s_q;

    // R2: a non-negative gradient leaves with an identical score.
    p_score_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !g_q[PW-1] |-> (s_q == g_q));

    // R2: a score is never negative.
    p_score_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q[PW-1]);

endmodule

// File: rtl/igs_seq.sv
// Module: job sequencer. Loads the error vector, then the feature beats, and
// then sweeps the weight matrix row by row, issuing one beat per advance. It
// also keeps the busy, done and tuple-count state.
// Assumes start is only raised while idle with valid dimensions.
module igs_seq
    import igs_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int DW      = 16,
    parameter int MAX_IN  = 256,
    parameter int MAX_OUT = 64,
    parameter int IDXW    = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [15:0]         n_in_i,
    input  logic [15:0]         n_out_i,
    input  logic                err_tvalid,
    output logic                err_tready,
    input  logic [DW-1:0]       err_tdata,
    input  logic                feat_tvalid,
    output logic                feat_tready,
    input  logic [LANES*DW-1:0] feat_tdata,
    input  logic                adv_i,
    output logic                iss_valid,
    output logic [LANES*DW-1:0] iss_x,
    output logic [DW-1:0]       iss_e,
    output logic [LANES-1:0]    iss_keep,
    output logic [IDXW-1:0]     iss_idx,
    output logic                iss_last,
    input  logic                out_fire,
    input  logic                out_last,
    input  logic [LANES-1:0]    out_keep,
    output logic                busy_o,
    output logic                done_o,
    output logic [31:0]         count_o
);

    localparam int FBEATS = (MAX_IN + LANES - 1) / LANES;
    localparam int FAW    = (FBEATS > 1) ? $clog2(FBEATS) : 1;
    localparam int EAW    = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1;
    localparam logic [15:0] LANES_W = 16'(LANES);

    seq_state_t          state;
    logic [DW-1:0]       err_mem  [MAX_OUT];
    logic [LANES*DW-1:0] feat_mem [FBEATS];
    logic [EAW-1:0]      ecnt;
    logic [FAW-1:0]      fcnt;
    logic [EAW-1:0]      row;
    logic [FAW-1:0]      col;
    logic [EAW-1:0]      n_out_m1;
    logic [FAW-1:0]      nb_m1;
    logic [15:0]         n_in_q;
    logic [15:0]         base_i;
    logic [IDXW-1:0]     row_base;

    assign err_tready  = (state == ST_ERR);
    assign feat_tready = (state == ST_FEAT);
    assign iss_valid   = (state == ST_RUN);
    assign iss_x       = feat_mem[col];
    assign iss_e       = err_mem[row];
    assign iss_idx     = row_base + IDXW'(base_i);
    assign iss_last    = (row == n_out_m1) && (col == nb_m1);

    // Purpose: mark the lanes of the current beat that fall inside the row.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            iss_keep[k] = (base_i + 16'(k)) < n_in_q;
        end
    end

    // Purpose: capture error elements and feature beats as they are accepted.
    always_ff @(posedge clk) begin
        if (state == ST_ERR && err_tvalid) begin
            err_mem[ecnt] <= err_tdata;
        end
        if (state == ST_FEAT && feat_tvalid) begin
            feat_mem[fcnt] <= feat_tdata;
        end
    end

    // Purpose: step through the load and sweep phases and keep busy, done and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            busy_o   <= 1'b0;
            done_o   <= 1'b0;
            count_o  <= '0;
            ecnt     <= '0;
            fcnt     <= '0;
            row      <= '0;
            col      <= '0;
            n_out_m1 <= '0;
            nb_m1    <= '0;
            n_in_q   <= '0;
            base_i   <= '0;
            row_base <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state    <= ST_ERR;
                        busy_o   <= 1'b1;
                        done_o   <= 1'b0;
                        count_o  <= '0;
                        ecnt     <= '0;
                        n_in_q   <= n_in_i;
                        n_out_m1 <= EAW'(n_out_i - 16'd1);
                        nb_m1    <= FAW'((n_in_i - 16'd1) / LANES_W);
                    end
                end
                ST_ERR: begin
                    if (err_tvalid) begin
                        if (ecnt == n_out_m1) begin
                            state <= ST_FEAT;
                            fcnt  <= '0;
                        end else begin
                            ecnt <= ecnt + 1'b1;
                        end
                    end
                end
                ST_FEAT: begin
                    if (feat_tvalid) begin
                        if (fcnt == nb_m1) begin
                            state    <= ST_RUN;
                            row      <= '0;
                            col      <= '0;
                            base_i   <= '0;
                            row_base <= '0;
                        end else begin
                            fcnt <= fcnt + 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (adv_i) begin
                        if (col == nb_m1) begin
                            col      <= '0;
                            base_i   <= '0;
                            row_base <= row_base + IDXW'(n_in_q);
                            if (row == n_out_m1) begin
                                state <= ST_DRAIN;
                            end else begin
                                row <= row + 1'b1;
                            end
                        end else begin
                            col    <= col + 1'b1;
                            base_i <= base_i + LANES_W;
                        end
                    end
                end
                ST_DRAIN: begin
                end
                default: state <= ST_IDLE;
            endcase
            if (out_fire) begin
                count_o <= count_o + 32'($countones(out_keep));
                if (out_last) begin
                    state  <= ST_IDLE;
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    // R4: feature loading is only ever entered straight from error loading.
    p_feat_after_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(feat_tready) |-> $past(err_tready));

    // R8: done rises only on the clock the last beat is taken.
    p_done_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(out_fire && out_last));

    // R9: the tuple count never falls while a job runs.
    p_count_grows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (count_o >= $past(count_o)));

endmodule

// File: rtl/igs_scorer.sv
// Module: top of the local-gradient importance scorer. It joins the register
// block, the sequencer and LANES gradient lanes. The pipeline runs one beat per
// clock and is frozen as a whole when the output beat is stalled.
// Assumes MAX_IN*MAX_OUT weight indices fit in IDXW bits.
module igs_scorer
    import igs_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int DW      = 16,
    parameter int MAX_IN  = 256,
    parameter int MAX_OUT = 64,
    parameter int IDXW    = $clog2(MAX_IN * MAX_OUT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    csr_awvalid,
    output logic                    csr_awready,
    input  logic [3:0]              csr_awaddr,
    input  logic                    csr_wvalid,
    output logic                    csr_wready,
    input  logic [31:0]             csr_wdata,
    output logic                    csr_bvalid,
    input  logic                    csr_bready,
    output logic [1:0]              csr_bresp,
    input  logic                    csr_arvalid,
    output logic                    csr_arready,
    input  logic [3:0]              csr_araddr,
    output logic                    csr_rvalid,
    input  logic                    csr_rready,
    output logic [31:0]             csr_rdata,
    output logic [1:0]              csr_rresp,
    input  logic                    err_tvalid,
    output logic                    err_tready,
    input  logic [DW-1:0]           err_tdata,
    input  logic                    feat_tvalid,
    output logic                    feat_tready,
    input  logic [LANES*DW-1:0]     feat_tdata,
    output logic                    out_tvalid,
    input  logic                    out_tready,
    output logic                    out_tlast,
    output logic [LANES-1:0]        out_tkeep,
    output logic [IDXW-1:0]         out_index,
    output logic [LANES*2*DW-1:0]   out_grad,
    output logic [LANES*2*DW-1:0]   out_score
);

    localparam int PW = 2 * DW;

    logic                start;
    logic [15:0]         n_in;
    logic [15:0]         n_out;
    logic                busy;
    logic                done;
    logic [31:0]         count;
    logic                adv;
    logic                out_fire;
    logic                iss_valid;
    logic [LANES*DW-1:0] iss_x;
    logic [DW-1:0]       iss_e;
    logic [LANES-1:0]    iss_keep;
    logic [IDXW-1:0]     iss_idx;
    logic                iss_last;
    logic                va;
    logic                vb;
    logic [IDXW-1:0]     a_idx;
    logic [IDXW-1:0]     b_idx;
    logic [LANES-1:0]    a_keep;
    logic [LANES-1:0]    b_keep;
    logic                a_last;
    logic                b_last;

    // Purpose: the pipeline moves unless a valid output beat is being held back.
    assign adv      = !vb || out_tready;
    assign out_fire = vb && out_tready;

    assign out_tvalid = vb;
    assign out_tlast  = b_last;
    assign out_tkeep  = b_keep;
    assign out_index  = b_idx;

    igs_csr #(.MAX_IN(MAX_IN), .MAX_OUT(MAX_OUT)) u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .awvalid (csr_awvalid),
        .awready (csr_awready),
        .awaddr  (csr_awaddr),
        .wvalid  (csr_wvalid),
        .wready  (csr_wready),
        .wdata   (csr_wdata),
        .bvalid  (csr_bvalid),
        .bready  (csr_bready),
        .bresp   (csr_bresp),
        .arvalid (csr_arvalid),
        .arready (csr_arready),
        .araddr  (csr_araddr),
        .rvalid  (csr_rvalid),
        .rready  (csr_rready),
        .rdata   (csr_rdata),
        .rresp   (csr_rresp),
        .busy_i  (busy),
        .done_i  (done),
        .count_i (count),
        .n_in_o  (n_in),
        .n_out_o (n_out),
        .start_o (start)
    );

    igs_seq #(
        .LANES(LANES), .DW(DW), .MAX_IN(MAX_IN), .MAX_OUT(MAX_OUT), .IDXW(IDXW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .n_in_i      (n_in),
        .n_out_i     (n_out),
        .err_tvalid  (err_tvalid),
        .err_tready  (err_tready),
        .err_tdata   (err_tdata),
        .feat_tvalid (feat_tvalid),
        .feat_tready (feat_tready),
        .feat_tdata  (feat_tdata),
        .adv_i       (adv),
        .iss_valid   (iss_valid),
        .iss_x       (iss_x),
        .iss_e       (iss_e),
        .iss_keep    (iss_keep),
        .iss_idx     (iss_idx),
        .iss_last    (iss_last),
        .out_fire    (out_fire),
        .out_last    (b_last),
        .out_keep    (b_keep),
        .busy_o      (busy),
        .done_o      (done),
        .count_o     (count)
    );

    // Purpose: carry valid, index, keep and last alongside the two lane stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va     <= 1'b0;
            vb     <= 1'b0;
            a_idx  <= '0;
            b_idx  <= '0;
            a_keep <= '0;
            b_keep <= '0;
            a_last <= 1'b0;
            b_last <= 1'b0;
        end else if (adv) begin
            va     <= iss_valid;
            a_idx  <= iss_idx;
            a_keep <= iss_keep;
            a_last <= iss_valid && iss_last;
            vb     <= va;
            b_idx  <= a_idx;
            b_keep <= a_keep;
            b_last <= a_last;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [DW-1:0] x_m;
        // Purpose: zero the feature of a lane beyond the row so it yields nothing.
        assign x_m = iss_keep[k] ? iss_x[k*DW +: DW] : '0;
        igs_lane #(.DW(DW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (adv),
            .x_i     (x_m),
            .e_i     (iss_e),
            .grad_o  (out_grad[k*PW +: PW]),
            .score_o (out_score[k*PW +: PW])
        );
    end

    // R6: a stalled output beat keeps every field unchanged.
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tvalid && !out_tready) |=>
        (out_tvalid && $stable(out_index) && $stable(out_grad) &&
         $stable(out_tkeep) && $stable(out_tlast)));

    // R8: taking the last beat ends the busy state on the next clock.
    p_last_clears_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fire && out_tlast) |=> !busy);

    // R10: the dimensions seen by the sequencer stay fixed while busy.
    p_dims_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(n_in) && $stable(n_out)));

endmodule

// File: tb/igs_scorer_tb.sv
// Bench: scoreboard for the importance scorer. The job task queues the expected
// beats; a monitor pops and compares them on every output handshake.
module igs_scorer_tb;

    localparam int LANES   = 32;
    localparam int DW      = 16;
    localparam int PW      = 2 * DW;
    localparam int MAX_IN  = 256;
    localparam int MAX_OUT = 64;
    localparam int IDXW    = $clog2(MAX_IN * MAX_OUT);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  csr_awvalid = 1'b0;
    logic                  csr_awready;
    logic [3:0]            csr_awaddr = '0;
    logic                  csr_wvalid = 1'b0;
    logic                  csr_wready;
    logic [31:0]           csr_wdata = '0;
    logic                  csr_bvalid;
    logic                  csr_bready = 1'b1;
    logic [1:0]            csr_bresp;
    logic                  csr_arvalid = 1'b0;
    logic                  csr_arready;
    logic [3:0]            csr_araddr = '0;
    logic                  csr_rvalid;
    logic                  csr_rready = 1'b1;
    logic [31:0]           csr_rdata;
    logic [1:0]            csr_rresp;
    logic                  err_tvalid = 1'b0;
    logic                  err_tready;
    logic [DW-1:0]         err_tdata = '0;
    logic                  feat_tvalid = 1'b0;
    logic                  feat_tready;
    logic [LANES*DW-1:0]   feat_tdata = '0;
    logic                  out_tvalid;
    logic                  out_tready = 1'b1;
    logic                  out_tlast;
    logic [LANES-1:0]      out_tkeep;
    logic [IDXW-1:0]       out_index;
    logic [LANES*PW-1:0]   out_grad;
    logic [LANES*PW-1:0]   out_score;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int bp_mode  = 0;
    int seen     = 0;
    int first_c  = 0;
    int last_c   = 0;

    logic [15:0]         xv [MAX_IN];
    logic [15:0]         ev [MAX_OUT];
    logic [31:0]         seed = 32'h1234_5678;
    logic [IDXW-1:0]     q_idx  [$];
    logic [LANES-1:0]    q_keep [$];
    logic                q_last [$];
    logic [LANES*PW-1:0] q_grad [$];

    logic                prev_stall = 1'b0;
    logic [IDXW-1:0]     prev_idx;
    logic [LANES*PW-1:0] prev_grad;

    igs_scorer #(.LANES(LANES), .DW(DW), .MAX_IN(MAX_IN), .MAX_OUT(MAX_OUT)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .csr_awvalid(csr_awvalid), .csr_awready(csr_awready), .csr_awaddr(csr_awaddr),
        .csr_wvalid(csr_wvalid), .csr_wready(csr_wready), .csr_wdata(csr_wdata),
        .csr_bvalid(csr_bvalid), .csr_bready(csr_bready), .csr_bresp(csr_bresp),
        .csr_arvalid(csr_arvalid), .csr_arready(csr_arready), .csr_araddr(csr_araddr),
        .csr_rvalid(csr_rvalid), .csr_rready(csr_rready), .csr_rdata(csr_rdata),
        .csr_rresp(csr_rresp),
        .err_tvalid(err_tvalid), .err_tready(err_tready), .err_tdata(err_tdata),
        .feat_tvalid(feat_tvalid), .feat_tready(feat_tready), .feat_tdata(feat_tdata),
        .out_tvalid(out_tvalid), .out_tready(out_tready), .out_tlast(out_tlast),
        .out_tkeep(out_tkeep), .out_index(out_index), .out_grad(out_grad),
        .out_score(out_score)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Output backpressure: always ready, or stalled one clock in three.
    always @(posedge clk) begin
        #1;
        if (bp_mode == 0) out_tready = 1'b1;
        else              out_tready = (cyc % 3) != 0;
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[30:15];
    endfunction

    // Monitor: compare every taken beat against the head of the queue, and check stalls.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                check(out_tvalid && out_index == prev_idx && out_grad == prev_grad,
                      "R6", "stalled beat changed", 64'(out_index), 64'(prev_idx));
            end
            prev_stall = out_tvalid && !out_tready;
            prev_idx   = out_index;
            prev_grad  = out_grad;
            if (out_tvalid && out_tready) begin
                if (q_idx.size() == 0) begin
                    check(1'b0, "R6", "extra beat", 64'(out_index), 64'd0);
                end else begin
                    logic [IDXW-1:0]     ei;
                    logic [LANES-1:0]    ek;
                    logic                el;
                    logic [LANES*PW-1:0] eg;
                    logic [LANES*PW-1:0] es;
                    ei = q_idx.pop_front();
                    ek = q_keep.pop_front();
                    el = q_last.pop_front();
                    eg = q_grad.pop_front();
                    for (int k = 0; k < LANES; k++) begin
                        logic signed [PW-1:0] g;
                        g = eg[k*PW +: PW];
                        es[k*PW +: PW] = (g < 0) ? -g : g;
                    end
                    check(out_index == ei, "R3", "index", 64'(out_index), 64'(ei));
                    check(out_tlast == el, "R3", "last", 64'(out_tlast), 64'(el));
                    check(out_tkeep == ek, "R5", "keep", 64'(out_tkeep), 64'(ek));
                    check(out_grad == eg, "R2", "gradient", 64'(out_grad[63:0]), 64'(eg[63:0]));
                    check(out_score == es, "R2", "score", 64'(out_score[63:0]), 64'(es[63:0]));
                    if (seen == 0) first_c = cyc;
                    last_c = cyc;
                    seen++;
                end
            end
        end
    end

    task automatic csr_write(input logic [3:0] a, input logic [31:0] d);
        csr_awaddr = a; csr_wdata = d; csr_awvalid = 1'b1; csr_wvalid = 1'b1;
        while (!csr_awready) @(negedge clk);
        @(negedge clk);
        csr_awvalid = 1'b0; csr_wvalid = 1'b0;
        @(negedge clk);
    endtask

    task automatic csr_read(input logic [3:0] a, output logic [31:0] d);
        csr_araddr = a; csr_arvalid = 1'b1;
        while (!csr_arready) @(negedge clk);
        @(negedge clk);
        csr_arvalid = 1'b0;
        while (!csr_rvalid) @(negedge clk);
        d = csr_rdata;
        @(negedge clk);
    endtask

    task automatic send_err(input logic [15:0] v);
        err_tdata = v; err_tvalid = 1'b1;
        while (!err_tready) @(negedge clk);
        @(negedge clk);
        err_tvalid = 1'b0;
    endtask

    task automatic send_feat(input logic [LANES*DW-1:0] v);
        feat_tdata = v; feat_tvalid = 1'b1;
        while (!feat_tready) @(negedge clk);
        @(negedge clk);
        feat_tvalid = 1'b0;
    endtask

    // Driver: queue expected beats, run one job, then check status and count.
    task automatic run_job(input int n_in, input int n_out, input int bp);
        int nb;
        logic [31:0] r;
        nb = (n_in + LANES - 1) / LANES;
        bp_mode = bp;
        seen = 0;
        for (int j = 0; j < n_out; j++) begin
            for (int b = 0; b < nb; b++) begin
                logic [LANES-1:0]    kp;
                logic [LANES*PW-1:0] gv;
                for (int k = 0; k < LANES; k++) begin
                    int i;
                    i = b * LANES + k;
                    kp[k] = i < n_in;
                    gv[k*PW +: PW] = kp[k] ? 32'(int'($signed(xv[i])) * int'($signed(ev[j]))) : '0;
                end
                q_idx.push_back(IDXW'(j * n_in + b * LANES));
                q_keep.push_back(kp);
                q_last.push_back((j == n_out - 1) && (b == nb - 1));
                q_grad.push_back(gv);
            end
        end
        csr_write(4'h4, {16'(n_out), 16'(n_in)});
        csr_read(4'h4, r);
        check(r == {16'(n_out), 16'(n_in)}, "R11", "dims readback", 64'(r), 64'({16'(n_out), 16'(n_in)}));
        csr_write(4'h0, 32'd1);
        csr_read(4'h8, r);
        check(r[1:0] == 2'b01, "R8", "status after start", 64'(r), 64'd1);
        csr_read(4'hC, r);
        check(r == 32'd0, "R9", "count cleared at start", 64'(r), 64'd0);
        csr_write(4'h4, 32'h0001_0001);
        csr_write(4'h0, 32'd1);
        csr_read(4'h4, r);
        check(r == {16'(n_out), 16'(n_in)}, "R10", "dims write while busy", 64'(r), 64'({16'(n_out), 16'(n_in)}));
        check(err_tready && !feat_tready, "R4", "error phase readies", 64'({err_tready, feat_tready}), 64'h2);
        for (int j = 0; j < n_out; j++) send_err(ev[j]);
        check(!err_tready && feat_tready, "R4", "feature phase readies", 64'({err_tready, feat_tready}), 64'h1);
        for (int b = 0; b < nb; b++) begin
            logic [LANES*DW-1:0] fb;
            for (int k = 0; k < LANES; k++) begin
                int i;
                i = b * LANES + k;
                fb[k*DW +: DW] = (i < n_in) ? xv[i] : 16'h7FFF;
            end
            send_feat(fb);
        end
        r = '0;
        while (!r[1]) csr_read(4'h8, r);
        check(r[1:0] == 2'b10, "R8", "status after job", 64'(r), 64'd2);
        csr_read(4'hC, r);
        check(r == 32'(n_in * n_out), "R9", "tuple count", 64'(r), 64'(n_in * n_out));
        check(q_idx.size() == 0 && seen == nb * n_out, "R6", "beats delivered",
              64'(seen), 64'(nb * n_out));
        if (bp == 0) begin
            check(last_c - first_c == nb * n_out - 1, "R7", "back-to-back beats",
                  64'(last_c - first_c), 64'(nb * n_out - 1));
        end
    endtask

    task automatic try_bad(input logic [31:0] dims);
        logic [31:0] r;
        csr_write(4'h4, dims);
        csr_write(4'h0, 32'd1);
        csr_read(4'h8, r);
        check(r[1:0] == 2'b10, "R10", "rejected start status", 64'(r), 64'd2);
        check(!err_tready && !out_tvalid, "R10", "rejected start idle", 64'({err_tready, out_tvalid}), 64'd0);
    endtask

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        check(!out_tvalid && !err_tready && !feat_tready, "R1", "reset outputs",
              64'({out_tvalid, err_tready, feat_tready}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        csr_read(4'h8, r);
        check(r == 32'd0, "R1", "reset status", 64'(r), 64'd0);
        csr_read(4'hC, r);
        check(r == 32'd0, "R1", "reset count", 64'(r), 64'd0);

        for (int i = 0; i < MAX_IN; i++) xv[i] = rnd();
        for (int j = 0; j < MAX_OUT; j++) ev[j] = rnd();
        run_job(40, 3, 0);

        try_bad(32'h0003_0000);
        try_bad(32'h0041_0008);
        try_bad(32'h0001_0101);

        for (int i = 0; i < MAX_IN; i++) xv[i] = rnd();
        for (int j = 0; j < MAX_OUT; j++) ev[j] = rnd();
        run_job(64, 2, 1);

        for (int i = 0; i < MAX_IN; i++) xv[i] = (i % 2 == 0) ? 16'h8000 : 16'h7FFF;
        ev[0] = 16'h8000;
        run_job(32, 1, 0);

        for (int i = 0; i < MAX_IN; i++) xv[i] = rnd();
        for (int j = 0; j < MAX_OUT; j++) ev[j] = rnd();
        run_job(1, MAX_OUT, 1);
        run_job(MAX_IN, 1, 0);

        $display("  test done: total=%0d bad=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_checks, n_fail);
        $finish;
    end

endmodule